// File: doc/BRIEF.md
# Five-Valued Stuck-Fault Propagation Evaluator

The block evaluates a fixed two-gate netlist in discrepancy logic. A two-input AND gate takes primary inputs `a` and `b`, and its output drives one input of a two-input OR gate. The other OR input is primary input `c`. Every wire carries a pair of values: the value in a healthy circuit and the value in a circuit with one stuck fault. A single evaluation pass therefore shows whether the fault reaches the output. There is no need to simulate a healthy copy and a faulty copy of the circuit separately.

The caller drives the three primary inputs, each as 0, 1 or unknown, and a fault descriptor. The descriptor names one of the five wires and the value that wire is stuck at. The block registers three results: the five-valued code at the output, a flag that the output shows a discrepancy (the vector detects the fault), and a flag that the faulted wire itself shows a discrepancy (the vector activates the fault). A small sweep engine, started by a one-cycle pulse, tries the eight fully specified input vectors in ascending order against the same fault descriptor. It reports the first vector that detects the fault, or reports that none does.

Top module: `fv_fault_eval`

## Requirements
- R1: A symbol is three bits {known, good, faulty}. Zero is 3'b100, one is 3'b111, D (good 1, faulty 0) is 3'b110, D-bar (good 0, faulty 1) is 3'b101, and unknown is reported as 3'b000. Each primary input is two bits {known, value}: 2'b10 means 0, 2'b11 means 1, and known=0 means unknown.
- R2: Each gate is evaluated pairwise. The gate function is applied to the good components and, separately, to the faulty components.
- R3: Unknowns propagate conservatively. A gate output is known only when its known inputs force it. For example, an unknown ANDed with 0 gives 0, and an unknown ORed with 1 gives 1. Otherwise the output is unknown.
- R4: With the fault enabled, the faulty component of the named wire is forced to the stuck value and its good component is left unchanged. The wire indices are 0 for input a, 1 for input b, 2 for input c, 3 for the AND output and 4 for the primary output. If the named wire is unknown, it stays unknown.
- R5: With the enable low, or with a wire index of 5 to 7, no fault is injected. The output then equals the healthy value, and both the detect flag and the activation flag stay low.
- R6: The detect flag is high exactly when the output code is D or D-bar.
- R7: The activation flag is high exactly when the faulted wire, after injection, holds D or D-bar. This flag is independent of whether the discrepancy reaches the output.
- R8: The output code and both flags are registered, with one clock of latency from the inputs. A synchronous active-high reset sets the code to 3'b000 and clears every flag.
- R9: A start pulse while the sweep engine is idle begins a sweep of vectors 0 to 7, one vector per clock, with {a,b,c} taken from bits [2:1:0] of the vector number. At the first detecting vector v, done and found rise on the (v+1)-th clock after the start edge, and the vector output holds v.
- R10: If none of the eight vectors detects the fault, done rises on the 8th clock after the start edge, with found low.
- R11: A start pulse is ignored while a sweep is busy. After done rises, done, found and the vector output hold their values until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | 2 | Primary input a, {known, value} |
| b_in | input | 2 | Primary input b, {known, value} |
| c_in | input | 2 | Primary input c, {known, value} |
| flt_en | input | 1 | Fault enable |
| flt_wire | input | 3 | Faulted wire index |
| flt_val | input | 1 | Stuck value |
| out_code | output | 3 | Registered output symbol {known, good, faulty} |
| detect | output | 1 | Output symbol is D or D-bar |
| activ | output | 1 | Faulted wire holds D or D-bar |
| sweep_start | input | 1 | Start pulse for the vector sweep |
| sweep_busy | output | 1 | Sweep in progress |
| sweep_done | output | 1 | Sweep finished |
| sweep_found | output | 1 | A detecting vector was found |
| sweep_vec | output | 3 | First detecting vector {a,b,c} |

## Verification
A wrong fault-injection site or a wrong pairwise gate function changes `out_code` on the very next clock for a vector that sensitizes that wire. The directed vectors therefore place D or D-bar on each wire and either propagate or block it. Broken unknown handling shows up one clock later as a known code where 3'b000 is expected, or as 3'b000 where a masked value is expected. A faulty sweep counter or stop condition shows up as a wrong `sweep_vec`, or as `sweep_done` rising on a clock other than v+1 after the start edge. Both are measured directly.

// File: rtl/fvx_pkg.sv
package fvx_pkg;
  localparam int N_PI   = 3;
  localparam int WIRE_W = 3;
  localparam int N_WIRE = 5;
  localparam int SYM_W  = 3;

  typedef struct packed {
    logic known;
    logic good;
    logic bad;
  } sym_t;

  typedef enum logic {OP_AND = 1'b0, OP_OR = 1'b1} gop_e;

  // primary input code {known, value} to a pair symbol
  function automatic sym_t sym_from_in(input logic [1:0] code);
    sym_t s;
    s.known = code[1];
    s.good  = code[1] & code[0];
    s.bad   = code[1] & code[0];
    return s;
  endfunction

  // force the faulty half of a known wire; unknown wires stay unknown
  function automatic sym_t inject(input sym_t s, input logic hit, input logic v);
    sym_t r;
    r = s;
    if (hit && s.known) r.bad = v;
    if (!r.known) begin
      r.good = 1'b0;
      r.bad  = 1'b0;
    end
    return r;
  endfunction

  function automatic logic is_disc(input sym_t s);
    return s.known & (s.good ^ s.bad);
  endfunction
endpackage

// File: rtl/fv_gate.sv
module fv_gate
  import fvx_pkg::*;
#(
  parameter gop_e OP = OP_AND
) (
  input  sym_t x,
  input  sym_t y,
  output sym_t z
);
  logic g_det, g_val, f_det, f_val;

  generate
    if (OP == OP_AND) begin : g_and
      always_comb begin
        g_det = (x.known & y.known) | (x.known & ~x.good) | (y.known & ~y.good);
        g_val = x.known & y.known & x.good & y.good;
        f_det = (x.known & y.known) | (x.known & ~x.bad) | (y.known & ~y.bad);
        f_val = x.known & y.known & x.bad & y.bad;
      end
    end else begin : g_or
      always_comb begin
        g_det = (x.known & y.known) | (x.known & x.good) | (y.known & y.good);
        g_val = (x.known & x.good) | (y.known & y.good);
        f_det = (x.known & y.known) | (x.known & x.bad) | (y.known & y.bad);
        f_val = (x.known & x.bad) | (y.known & y.bad);
      end
    end
  endgenerate

  always_comb begin
    z.known = g_det & f_det;
    z.good  = g_det & f_det & g_val;
    z.bad   = g_det & f_det & f_val;
  end

  // R3
  always_comb begin
    if (z.known && !x.known && !y.known) begin
      x_origin_chk: assert (1'b0 == 1'b1)
        else $error("known gate output from two unknown inputs");
    end
  end
endmodule

// File: rtl/fv_net.sv
module fv_net
  import fvx_pkg::*;
(
  input  sym_t              a,
  input  sym_t              b,
  input  sym_t              c,
  input  logic              flt_en,
  input  logic [WIRE_W-1:0] flt_wire,
  input  logic              flt_val,
  output sym_t              y,
  output logic              act
);
  logic [N_WIRE-1:0] hit;
  sym_t a_f, b_f, c_f, n_raw, n_f, y_raw, site;

  for (genvar i = 0; i < N_WIRE; i++) begin : g_hit
    assign hit[i] = flt_en && (flt_wire == WIRE_W'(i));
  end

  assign a_f = inject(a, hit[0], flt_val);
  assign b_f = inject(b, hit[1], flt_val);
  assign c_f = inject(c, hit[2], flt_val);

  fv_gate #(.OP(OP_AND)) u_and (.x(a_f), .y(b_f), .z(n_raw));
  assign n_f = inject(n_raw, hit[3], flt_val);

  fv_gate #(.OP(OP_OR)) u_or (.x(n_f), .y(c_f), .z(y_raw));
  assign y = inject(y_raw, hit[4], flt_val);

  always_comb begin
    case (flt_wire)
      3'd0:    site = a_f;
      3'd1:    site = b_f;
      3'd2:    site = c_f;
      3'd3:    site = n_f;
      3'd4:    site = y;
      default: site = '0;
    endcase
    act = (|hit) & is_disc(site);
  end

  // R7
  always_comb begin
    if (is_disc(y)) begin
      prop_needs_act_chk: assert (act)
        else $error("output discrepancy without activation");
    end
  end
endmodule

// File: rtl/fv_sweep.sv
module fv_sweep
  import fvx_pkg::*;
#(
  parameter int NPI = N_PI
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              flt_en,
  input  logic [WIRE_W-1:0] flt_wire,
  input  logic              flt_val,
  output logic              busy,
  output logic              done,
  output logic              found,
  output logic [NPI-1:0]    vec
);
  localparam logic [NPI-1:0] LAST = '1;

  logic [NPI-1:0] idx;
  sym_t sa, sb, sc, sy;
  logic s_act, hit_now;

  assign sa = sym_from_in({1'b1, idx[NPI-1]});
  assign sb = sym_from_in({1'b1, idx[NPI-2]});
  assign sc = sym_from_in({1'b1, idx[NPI-3]});

  fv_net u_net (
    .a(sa), .b(sb), .c(sc),
    .flt_en(flt_en), .flt_wire(flt_wire), .flt_val(flt_val),
    .y(sy), .act(s_act)
  );

  assign hit_now = is_disc(sy) & s_act;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      found <= 1'b0;
      idx   <= '0;
      vec   <= '0;
    end else if (!busy && start) begin
      busy  <= 1'b1;
      done  <= 1'b0;
      found <= 1'b0;
      idx   <= '0;
    end else if (busy) begin
      if (hit_now) begin
        busy  <= 1'b0;
        done  <= 1'b1;
        found <= 1'b1;
        vec   <= idx;
      end else if (idx == LAST) begin
        busy  <= 1'b0;
        done  <= 1'b1;
      end else begin
        idx <= idx + 1'b1;
      end
    end
  end

  // R11
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({busy, done}));
  // R9
  found_implies_done_chk: assert property (@(posedge clk) disable iff (rst)
    found |-> done);
  // R11
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> (done && $stable(found) && $stable(vec)));
endmodule

// File: rtl/fv_fault_eval.sv
module fv_fault_eval
  import fvx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        a_in,
  input  logic [1:0]        b_in,
  input  logic [1:0]        c_in,
  input  logic              flt_en,
  input  logic [WIRE_W-1:0] flt_wire,
  input  logic              flt_val,
  output logic [SYM_W-1:0]  out_code,
  output logic              detect,
  output logic              activ,
  input  logic              sweep_start,
  output logic              sweep_busy,
  output logic              sweep_done,
  output logic              sweep_found,
  output logic [N_PI-1:0]   sweep_vec
);
  sym_t y_now;
  logic act_now;

  fv_net u_net (
    .a(sym_from_in(a_in)), .b(sym_from_in(b_in)), .c(sym_from_in(c_in)),
    .flt_en(flt_en), .flt_wire(flt_wire), .flt_val(flt_val),
    .y(y_now), .act(act_now)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_code <= '0;
      detect   <= 1'b0;
      activ    <= 1'b0;
    end else begin
      out_code <= y_now;
      detect   <= is_disc(y_now);
      activ    <= act_now;
    end
  end

  fv_sweep #(.NPI(N_PI)) u_sweep (
    .clk(clk), .rst(rst), .start(sweep_start),
    .flt_en(flt_en), .flt_wire(flt_wire), .flt_val(flt_val),
    .busy(sweep_busy), .done(sweep_done), .found(sweep_found), .vec(sweep_vec)
  );

  // R5
  fault_off_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !flt_en |=> (!detect && !activ));
  // R6
  detect_code_chk: assert property (@(posedge clk) disable iff (rst)
    detect |-> (out_code[2] && (out_code[1] ^ out_code[0])));
endmodule

// File: tb/fv_fault_eval_test.sv
module fv_fault_eval_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] a_in = 2'b10, b_in = 2'b10, c_in = 2'b10;
  logic flt_en = 1'b0;
  logic [2:0] flt_wire = 3'd0;
  logic flt_val = 1'b0;
  logic sweep_start = 1'b0;
  logic [2:0] out_code;
  logic detect, activ, sweep_busy, sweep_done, sweep_found;
  logic [2:0] sweep_vec;

  int checks = 0;
  int errors = 0;

  localparam logic [1:0] I0 = 2'b10, I1 = 2'b11, IX = 2'b00;
  localparam logic [2:0] S0 = 3'b100, S1 = 3'b111, SD = 3'b110, SDB = 3'b101, SX = 3'b000;

  always #5 clk = ~clk;

  fv_fault_eval uut (
    .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in), .c_in(c_in),
    .flt_en(flt_en), .flt_wire(flt_wire), .flt_val(flt_val),
    .out_code(out_code), .detect(detect), .activ(activ),
    .sweep_start(sweep_start), .sweep_busy(sweep_busy), .sweep_done(sweep_done),
    .sweep_found(sweep_found), .sweep_vec(sweep_vec)
  );

  task automatic chk(input string req, input logic [7:0] act_v, input logic [7:0] exp_v);
    checks++;
    if (act_v !== exp_v) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act_v, exp_v);
    end
  endtask

  task automatic eval_case(input string req, input logic [1:0] a, input logic [1:0] b,
                           input logic [1:0] c, input logic en, input logic [2:0] w,
                           input logic v, input logic [2:0] e_code, input logic e_det,
                           input logic e_act);
    @(negedge clk);
    a_in = a; b_in = b; c_in = c; flt_en = en; flt_wire = w; flt_val = v;
    @(posedge clk);
    @(negedge clk);
    chk({req, " code"}, {5'b0, out_code}, {5'b0, e_code});
    chk({req, " detect"}, {7'b0, detect}, {7'b0, e_det});
    chk({req, " activ"}, {7'b0, activ}, {7'b0, e_act});
  endtask

  task automatic sweep_case(input string req, input logic en, input logic [2:0] w,
                            input logic v, input logic e_found, input logic [2:0] e_vec,
                            input int e_lat, input bit restart_mid);
    int n;
    @(negedge clk);
    flt_en = en; flt_wire = w; flt_val = v; sweep_start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    sweep_start = 1'b0;
    n = 0;
    while (n < 20) begin
      if (restart_mid && n == 2) sweep_start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      sweep_start = 1'b0;
      n++;
      if (sweep_done) break;
    end
    chk({req, " latency"}, 8'(n), 8'(e_lat));
    chk({req, " found"}, {7'b0, sweep_found}, {7'b0, e_found});
    if (e_found) chk({req, " vec"}, {5'b0, sweep_vec}, {5'b0, e_vec});
    if (restart_mid) begin
      repeat (3) @(negedge clk);
      chk({req, " hold done"}, {7'b0, sweep_done}, 8'd1);
      chk({req, " hold vec"}, {5'b0, sweep_vec}, {5'b0, e_vec});
    end
  endtask

  task automatic reset_case();
    repeat (2) @(negedge clk);
    rst = 1'b0;
    chk("R8 reset code", {5'b0, out_code}, {5'b0, SX});
    chk("R8 reset flags", {4'b0, detect, activ, sweep_busy, sweep_done}, 8'd0);
    chk("R8 reset sweep", {4'b0, sweep_found, sweep_vec}, 8'd0);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    reset_case();
    // R2 R5: healthy evaluation
    eval_case("R2 good and-or", I1, I1, I0, 1'b0, 3'd3, 1'b0, S1, 1'b0, 1'b0);
    eval_case("R2 good zero", I0, I1, I0, 1'b0, 3'd3, 1'b0, S0, 1'b0, 1'b0);
    // R4 R6: stuck-at-0 on AND output
    eval_case("R4 and sa0 D", I1, I1, I0, 1'b1, 3'd3, 1'b0, SD, 1'b1, 1'b1);
    eval_case("R7 and sa0 blocked", I1, I1, I1, 1'b1, 3'd3, 1'b0, S1, 1'b0, 1'b1);
    eval_case("R7 and sa0 not activated", I0, I1, I0, 1'b1, 3'd3, 1'b0, S0, 1'b0, 1'b0);
    eval_case("R1 and sa1 Dbar", I0, I1, I0, 1'b1, 3'd3, 1'b1, SDB, 1'b1, 1'b1);
    eval_case("R4 input a sa1", I0, I1, I0, 1'b1, 3'd0, 1'b1, SDB, 1'b1, 1'b1);
    eval_case("R4 input b sa0", I1, I1, I0, 1'b1, 3'd1, 1'b0, SD, 1'b1, 1'b1);
    eval_case("R4 output sa0", I0, I0, I1, 1'b1, 3'd4, 1'b0, SD, 1'b1, 1'b1);
    eval_case("R4 input c sa1", I0, I0, I0, 1'b1, 3'd2, 1'b1, SDB, 1'b1, 1'b1);
    // R3: unknown handling
    eval_case("R3 x unmasked", IX, I1, I0, 1'b0, 3'd0, 1'b0, SX, 1'b0, 1'b0);
    eval_case("R3 x masked by and", IX, I0, I0, 1'b0, 3'd0, 1'b0, S0, 1'b0, 1'b0);
    eval_case("R3 x masked by or", IX, I1, I1, 1'b0, 3'd0, 1'b0, S1, 1'b0, 1'b0);
    eval_case("R3 fault on x wire", IX, I1, I0, 1'b1, 3'd3, 1'b0, SX, 1'b0, 1'b0);
    // R5: disabled and out-of-range fault
    eval_case("R5 enable low", I1, I1, I0, 1'b0, 3'd3, 1'b0, S1, 1'b0, 1'b0);
    eval_case("R5 index 6", I1, I1, I0, 1'b1, 3'd6, 1'b0, S1, 1'b0, 1'b0);
    // R9 R10 R11: sweeps
    sweep_case("R9 and sa0", 1'b1, 3'd3, 1'b0, 1'b1, 3'd6, 7, 1'b0);
    sweep_case("R9 c sa1", 1'b1, 3'd2, 1'b1, 1'b1, 3'd0, 1, 1'b0);
    sweep_case("R9 b sa1", 1'b1, 3'd1, 1'b1, 1'b1, 3'd4, 5, 1'b0);
    sweep_case("R9 a sa0", 1'b1, 3'd0, 1'b0, 1'b1, 3'd6, 7, 1'b0);
    sweep_case("R10 no fault", 1'b0, 3'd3, 1'b0, 1'b0, 3'd0, 8, 1'b0);
    sweep_case("R11 restart ignored", 1'b1, 3'd3, 1'b0, 1'b1, 3'd6, 7, 1'b1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule